// File: doc/BRIEF.md
# Parallel Host Bus Port for a Character Display Controller

This block is the microcontroller-facing parallel port of a character display controller. The host controls a strobe (`en_i`), a register-select line (`rs_i`), a direction line (`rw_i`) and an eight-line data bus. All of these pins are sampled with the controller's own clock through a chain of synchronizer flops. The strobe's edges are then found on the synchronized copy. A rising strobe opens a bus cycle and latches its kind. A falling strobe completes it.

Completed writes are handed to the internal logic as a one-cycle instruction-write or data-write pulse, with the assembled byte. Reads drive the bus through a value/enable pair (`db_o`, `db_oe_o`). A status read returns the busy flag on the top line and the address counter on the lines below it. A data read returns the byte supplied by the storage side and pulses a pop strobe once the whole byte has gone out.

The port can move a whole byte per strobe or one nibble per strobe. A mode bit, written by the instruction decoder, selects between the two. In nibble mode only the upper four lines carry information. The high nibble goes first, and an internal toggle tracks which half comes next.

Top module: `lcd_host_port`

## Requirements
- R1: After reset the port is in byte mode, the nibble toggle is cleared, `db_oe_o` is 0, `db_o` is 0 and no output pulse is active.
- R2: In byte mode, each write strobe (rw=0) produces exactly one one-cycle pulse after the strobe falls. The pulse is on `ins_wr_o` when rs=0 and on `dat_wr_o` when rs=1. `wr_byte_o` equals the data lines held while the strobe was high.
- R3: In nibble mode, a write takes two strobes. The first strobe carries bits 7:4 on lines 7:4, and the second carries bits 3:0 on lines 7:4. No pulse follows the first strobe. One pulse follows the second. Lines 3:0 have no effect on the byte.
- R4: `db_oe_o` is 1 only while a read strobe is high (rw=1 latched at the strobe's rise). It is 0 during and after every write strobe.
- R5: A status read (rs=0, rw=1) presents `{busy_i, addr_i}`, sampled at the strobe's rise, with the busy flag on line 7 and the address on lines 6:0. The value is held stable while driven, and no pop pulse follows.
- R6: A data read (rs=1, rw=1) presents `rd_data_i` and produces one `rd_pop_o` pulse once the byte is complete: after the single strobe in byte mode, and only after the second strobe in nibble mode.
- R7: In nibble mode, the first read strobe drives bits 7:4 on lines 7:4 and the second drives bits 3:0 on lines 7:4. Lines 3:0 read 0 in both.
- R8: A one-cycle `mode_wr_i` loads `mode_8b_i` into the mode bit (1 = byte, 0 = nibble) and clears the nibble toggle, so the next strobe is treated as a high nibble.
- R9: In nibble mode, the byte read out is sampled once, at the rise of the high-nibble strobe. The low nibble comes from that same sample even if `busy_i`, `addr_i` or `rd_data_i` have changed in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Host bus strobe |
| rs_i | input | 1 | Register select: 0 instruction/status, 1 data |
| rw_i | input | 1 | Direction: 1 read, 0 write |
| db_i | input | BUS_W | Data lines as seen from the host |
| db_o | output | BUS_W | Read value driven onto the data lines |
| db_oe_o | output | 1 | Output enable for the data lines |
| mode_wr_i | input | 1 | Mode update strobe from the instruction decoder |
| mode_8b_i | input | 1 | New mode: 1 byte transfers, 0 nibble transfers |
| busy_i | input | 1 | Busy flag of the internal logic |
| addr_i | input | BUS_W-1 | Current address counter |
| rd_data_i | input | BUS_W | Data byte for a data read |
| ins_wr_o | output | 1 | One-cycle instruction-write pulse |
| dat_wr_o | output | 1 | One-cycle data-write pulse |
| wr_byte_o | output | BUS_W | Byte accompanying a write pulse |
| rd_pop_o | output | 1 | One-cycle pulse when a data byte has been read |

## Verification
The assertions assume the following about the host:
- It holds `rs_i`, `rw_i` and the data lines steady for the whole strobe-high phase.
- It keeps each strobe level for more than the synchronizer depth plus one cycle.
- It never changes the mode while a strobe is high.

Given those assumptions, a write completion and a read drive never overlap, and the driven value cannot move while enabled.

The stimulus meets these assumptions by construction. Every pin changes only on the falling clock edge before the strobe rises. Each strobe is held high and then low for five cycles, and mode updates are issued only between strobes.

// File: rtl/lcd_host_pkg.sv
`timescale 1ns/1ps
package lcd_host_pkg;
  localparam int BUS_W_DEF = 8;
  localparam int SYNC_DEF  = 2;

  typedef struct packed {
    logic rs;
    logic rw;
  } cyc_ctl_t;
endpackage

// File: rtl/lcd_host_sync.sv
`timescale 1ns/1ps
module lcd_host_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/lcd_host_nibble.sv
`timescale 1ns/1ps
module lcd_host_nibble #(
  parameter int BUS_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_8b_i,
  input  logic             clr_i,
  input  logic             fall_i,
  input  logic [BUS_W-1:0] data_i,
  output logic             done_o,
  output logic             sel_o,
  output logic [BUS_W-1:0] byte_o
);
  localparam int NIB_W = BUS_W / 2;

  logic             sel_q;
  logic [NIB_W-1:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= 1'b0;
      hi_q  <= '0;
    end else if (clr_i) begin
      sel_q <= 1'b0;
    end else if (fall_i && !mode_8b_i) begin
      sel_q <= ~sel_q;
      if (!sel_q) hi_q <= data_i[BUS_W-1 -: NIB_W];
    end
  end

  assign done_o = fall_i && (mode_8b_i || sel_q);
  assign sel_o  = sel_q;
  assign byte_o = mode_8b_i ? data_i : {hi_q, data_i[BUS_W-1 -: NIB_W]};
endmodule

// File: rtl/lcd_host_rdmux.sv
`timescale 1ns/1ps
module lcd_host_rdmux #(
  parameter int BUS_W = 8
) (
  input  logic             mode_8b_i,
  input  logic             sel_i,
  input  logic [BUS_W-1:0] byte_i,
  output logic [BUS_W-1:0] drive_o
);
  localparam int NIB_W = BUS_W / 2;

  logic [NIB_W-1:0] nib;

  // nibble reads always use the upper lines
  assign nib     = sel_i ? byte_i[NIB_W-1:0] : byte_i[BUS_W-1 -: NIB_W];
  assign drive_o = mode_8b_i ? byte_i : {nib, {NIB_W{1'b0}}};
endmodule

// File: rtl/lcd_host_port.sv
`timescale 1ns/1ps
module lcd_host_port
  import lcd_host_pkg::*;
#(
  parameter int BUS_W       = BUS_W_DEF,
  parameter int SYNC_STAGES = SYNC_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             rs_i,
  input  logic             rw_i,
  input  logic [BUS_W-1:0] db_i,
  output logic [BUS_W-1:0] db_o,
  output logic             db_oe_o,
  input  logic             mode_wr_i,
  input  logic             mode_8b_i,
  input  logic             busy_i,
  input  logic [BUS_W-2:0] addr_i,
  input  logic [BUS_W-1:0] rd_data_i,
  output logic             ins_wr_o,
  output logic             dat_wr_o,
  output logic [BUS_W-1:0] wr_byte_o,
  output logic             rd_pop_o
);
  localparam int SW = BUS_W + 3;

  logic [SW-1:0]    pins_raw, pins_s;
  logic             en_s, rs_s, rw_s, en_q;
  logic [BUS_W-1:0] db_s, db_hold_q, rd_byte_q, asm_byte, rd_drive;
  logic             rise, fall, done, nib_sel;
  logic             mode_8b_q, oe_q;
  cyc_ctl_t         ctl_q;

  assign pins_raw = {en_i, rs_i, rw_i, db_i};

  lcd_host_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_raw),
    .q_o   (pins_s)
  );

  assign en_s = pins_s[SW-1];
  assign rs_s = pins_s[SW-2];
  assign rw_s = pins_s[SW-3];
  assign db_s = pins_s[BUS_W-1:0];
  assign rise = en_s && !en_q;
  assign fall = !en_s && en_q;

  lcd_host_nibble #(.BUS_W(BUS_W)) u_nib (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_8b_i(mode_8b_q),
    .clr_i    (mode_wr_i),
    .fall_i   (fall),
    .data_i   (db_hold_q),
    .done_o   (done),
    .sel_o    (nib_sel),
    .byte_o   (asm_byte)
  );

  lcd_host_rdmux #(.BUS_W(BUS_W)) u_rdmux (
    .mode_8b_i(mode_8b_q),
    .sel_i    (nib_sel),
    .byte_i   (rd_byte_q),
    .drive_o  (rd_drive)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      ctl_q     <= '0;
      db_hold_q <= '0;
      rd_byte_q <= '0;
      mode_8b_q <= 1'b1;
      oe_q      <= 1'b0;
      ins_wr_o  <= 1'b0;
      dat_wr_o  <= 1'b0;
      wr_byte_o <= '0;
      rd_pop_o  <= 1'b0;
    end else begin
      en_q <= en_s;
      if (mode_wr_i) mode_8b_q <= mode_8b_i;
      if (en_s) db_hold_q <= db_s;
      if (rise) begin
        ctl_q.rs <= rs_s;
        ctl_q.rw <= rw_s;
        if (rw_s) begin
          oe_q <= 1'b1;
          // low nibble reuses the byte taken at the high-nibble rise
          if (mode_8b_q || !nib_sel)
            rd_byte_q <= rs_s ? rd_data_i : {busy_i, addr_i};
        end
      end else if (fall) begin
        oe_q <= 1'b0;
      end
      ins_wr_o <= done && !ctl_q.rw && !ctl_q.rs;
      dat_wr_o <= done && !ctl_q.rw &&  ctl_q.rs;
      rd_pop_o <= done &&  ctl_q.rw &&  ctl_q.rs;
      if (done && !ctl_q.rw) wr_byte_o <= asm_byte;
    end
  end

  assign db_oe_o = oe_q;
  assign db_o    = oe_q ? rd_drive : '0;
endmodule

// File: rtl/lcd_host_port_chk.sv
`timescale 1ns/1ps
module lcd_host_port_chk #(
  parameter int BUS_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             db_oe_o,
  input logic [BUS_W-1:0] db_o,
  input logic             ins_wr_o,
  input logic             dat_wr_o,
  input logic             rd_pop_o,
  input logic             mode_8b_q,
  input logic             nib_sel
);
  p_one_event_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ins_wr_o, dat_wr_o, rd_pop_o}));

  p_wr_one_cycle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_wr_o || dat_wr_o) |=> !(ins_wr_o || dat_wr_o));

  p_no_drive_on_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_wr_o || dat_wr_o) |-> !db_oe_o);

  p_drive_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (db_oe_o && $past(db_oe_o)) |-> $stable(db_o));

  p_byte_mode_no_toggle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_8b_q |-> !nib_sel);

  p_idle_bus_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !db_oe_o |-> (db_o == '0));
endmodule

bind lcd_host_port lcd_host_port_chk #(.BUS_W(BUS_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .db_oe_o  (db_oe_o),
  .db_o     (db_o),
  .ins_wr_o (ins_wr_o),
  .dat_wr_o (dat_wr_o),
  .rd_pop_o (rd_pop_o),
  .mode_8b_q(mode_8b_q),
  .nib_sel  (nib_sel)
);

// File: tb/lcd_host_port_test.sv
`timescale 1ns/1ps
module lcd_host_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, rs = 1'b0, rw = 1'b0;
  logic [7:0] db = 8'h00;
  logic [7:0] db_o;
  logic       db_oe;
  logic       mode_wr = 1'b0, mode_8b = 1'b1;
  logic       busy = 1'b0;
  logic [6:0] addr = 7'h00;
  logic [7:0] rd_data = 8'h00;
  logic       ins_wr, dat_wr, rd_pop;
  logic [7:0] wr_byte;

  int checks = 0, errors = 0;
  int n_ins = 0, n_dat = 0, n_pop = 0;
  logic [7:0] last_byte = 8'h00;
  logic [7:0] seen;
  logic       seen_oe;

  always #2.5 clk = ~clk;

  lcd_host_port uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .rs_i(rs), .rw_i(rw), .db_i(db),
    .db_o(db_o), .db_oe_o(db_oe), .mode_wr_i(mode_wr), .mode_8b_i(mode_8b),
    .busy_i(busy), .addr_i(addr), .rd_data_i(rd_data), .ins_wr_o(ins_wr),
    .dat_wr_o(dat_wr), .wr_byte_o(wr_byte), .rd_pop_o(rd_pop)
  );

  always @(negedge clk) begin
    if (ins_wr) begin n_ins++; last_byte = wr_byte; end
    if (dat_wr) begin n_dat++; last_byte = wr_byte; end
    if (rd_pop) n_pop++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic s_rs, input logic s_rw, input logic [7:0] d);
    @(negedge clk);
    rs = s_rs; rw = s_rw; db = d;
    en = 1'b1;
    repeat (5) @(negedge clk);
    seen = db_o; seen_oe = db_oe;
    en = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic set_mode(input logic m);
    @(negedge clk);
    mode_8b = m; mode_wr = 1'b1;
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  initial begin
    #500us;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int pi, pd, pp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 oe", db_oe, 0);
    chk("R1 db_o", db_o, 0);
    chk("R1 pulses", n_ins + n_dat + n_pop, 0);

    // R2 / R4: byte-mode writes, all values, both targets
    for (int v = 0; v < 256; v++) begin
      for (int r = 0; r < 2; r++) begin
        pi = n_ins; pd = n_dat;
        strobe(r[0], 1'b0, v[7:0]);
        chk("R4 write not driven", seen_oe, 0);
        chk("R2 ins count", n_ins - pi, r == 0 ? 1 : 0);
        chk("R2 dat count", n_dat - pd, r == 1 ? 1 : 0);
        chk("R2 byte", last_byte, v);
      end
    end

    // R5: status reads in byte mode
    for (int a = 0; a < 128; a++) begin
      busy = a[0] ^ a[3]; addr = a[6:0];
      pp = n_pop;
      strobe(1'b0, 1'b1, 8'h5A);
      chk("R4 read driven", seen_oe, 1);
      chk("R5 status", seen, {a[0] ^ a[3], a[6:0]});
      chk("R5 no pop", n_pop - pp, 0);
      chk("R4 released", db_oe, 0);
    end

    // R6: data reads in byte mode
    for (int v = 0; v < 256; v += 7) begin
      rd_data = v[7:0] ^ 8'hC3;
      pp = n_pop;
      strobe(1'b1, 1'b1, 8'h00);
      chk("R6 data", seen, v ^ 8'hC3);
      chk("R6 pop", n_pop - pp, 1);
    end

    // R8: to nibble mode
    set_mode(1'b0);

    // R3: nibble writes, lower lines carry junk
    for (int v = 0; v < 256; v++) begin
      int r;
      r = v & 1;
      pi = n_ins; pd = n_dat;
      strobe(r[0], 1'b0, {v[7:4], ~v[3:0]});
      chk("R3 no pulse after high", (n_ins - pi) + (n_dat - pd), 0);
      strobe(r[0], 1'b0, {v[3:0], v[7:4]});
      chk("R3 one pulse", (n_ins - pi) + (n_dat - pd), 1);
      chk("R3 target", n_dat - pd, r);
      chk("R3 byte", last_byte, v);
    end

    // R7 / R6: nibble data reads
    for (int v = 0; v < 256; v += 5) begin
      rd_data = v[7:0];
      pp = n_pop;
      strobe(1'b1, 1'b1, 8'hFF);
      chk("R7 high nibble", seen, {v[7:4], 4'h0});
      chk("R6 no pop after high", n_pop - pp, 0);
      strobe(1'b1, 1'b1, 8'hFF);
      chk("R7 low nibble", seen, {v[3:0], 4'h0});
      chk("R6 pop after low", n_pop - pp, 1);
    end

    // R9: status byte sampled once per nibble pair
    busy = 1'b1; addr = 7'h5C;
    strobe(1'b0, 1'b1, 8'h00);
    chk("R9 high nibble", seen, 8'hD0);
    busy = 1'b0; addr = 7'h23;
    strobe(1'b0, 1'b1, 8'h00);
    chk("R9 low from first sample", seen, 8'hC0);
    rd_data = 8'hA7;
    strobe(1'b1, 1'b1, 8'h00);
    rd_data = 8'h18;
    strobe(1'b1, 1'b1, 8'h00);
    chk("R9 data low from first sample", seen, 8'h70);

    // R8: mode write clears toggle mid-pair
    pi = n_ins;
    strobe(1'b0, 1'b0, 8'hE0);
    set_mode(1'b0);
    strobe(1'b0, 1'b0, 8'h30);
    strobe(1'b0, 1'b0, 8'h90);
    chk("R8 toggle cleared count", n_ins - pi, 1);
    chk("R8 toggle cleared byte", last_byte, 8'h39);

    // R8: back to byte mode
    set_mode(1'b1);
    pd = n_dat;
    strobe(1'b1, 1'b0, 8'h6B);
    chk("R8 byte mode count", n_dat - pd, 1);
    chk("R8 byte mode value", last_byte, 8'h6B);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule